// File: doc/BRIEF.md
# Reset Boot Address Selector

This block decides where the processor fetches its first instruction once reset is released. When the synchronized system reset falls, it samples three external straps: program-store-enable, the programming-voltage detect on the external-access pin, and address-latch-enable. It then reads one or two configuration bytes from nonvolatile storage through a synchronous read port that answers one cycle after each request. From these it produces a 16-bit start address. A status byte of zero means execution starts at address zero. A nonzero status byte, or a forced strap condition, sends execution to the page named by the boot-vector byte. The start address is delivered with a single-cycle strobe.

The block also decodes program-fetch addresses at run time. A masked boot ROM overlays the top 1 KB of code space. One bit in an auxiliary control register removes the overlay, and the upper flash page then becomes visible instead. A small erase front end keeps the two configuration bytes linked: a request to erase either one erases both.

All interfaces are plain strobes and levels. The start strobe, the read requests and the erase pulse carry no ready signal and cannot be back-pressured. The nonvolatile store must return data on the cycle after every request, and the consumer of the start address must capture it on the strobe cycle.

Top module: `boot_start_sel`

## Requirements
- R1: A status byte (read address 0) of 00h, with no forced strap condition, gives start address 0000h.
- R2: A nonzero status byte gives start address {boot-vector byte, 00h}, where the boot vector is at read address 1. The low eight address bits are therefore always zero.
- R3: The forced path is taken when, at reset fall, psen_n_i=0, ea_hv_i=1 and ale_i=1. The start address is then {boot-vector byte, 00h}, whatever the status byte holds. Any other strap combination does not force.
- R4: The straps are sampled only in the cycle in which the synchronized reset is seen falling. Strap changes after that point do not alter the start address.
- R5: Each read request (nv_rd_en_o=1) is answered on nv_rd_data_i in the next cycle. A normal boot reads address 0, and then reads address 1 only if the status byte is nonzero. A forced boot reads only address 1.
- R6: start_valid_o is high for exactly one cycle per reset release. While sys_rst_i is high it stays low and no reads are issued.
- R7: With overlay enabled, fetch addresses FC00h–FFFFh set rom_sel_o=1, flash_sel_o=0 and rom_addr_o equal to the low 10 address bits. Every other address sets flash_sel_o=1, rom_sel_o=0 and rom_addr_o=0.
- R8: The auxiliary register (aux_q_o) resets to 00h and is loaded from aux_wdata_i when aux_wr_i=1. While its bit 5 is 1, every fetch address selects flash.
- R9: An erase request for either byte (erase_sel_i 0=status, 1=vector) drives nv_erase_o=2'b11 for exactly the following cycle. Otherwise nv_erase_o is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_i | input | 1 | System reset level, active high, asynchronous to clk |
| psen_n_i | input | 1 | Program-store-enable strap, active low |
| ea_hv_i | input | 1 | Programming voltage detected on the external-access pin |
| ale_i | input | 1 | Address-latch-enable strap (pulled high when floating) |
| nv_rd_en_o | output | 1 | Configuration read request |
| nv_rd_addr_o | output | 1 | 0 = status byte, 1 = boot-vector byte |
| nv_rd_data_i | input | 8 | Read data, valid one cycle after the request |
| start_valid_o | output | 1 | One-cycle strobe marking start_addr_o |
| start_addr_o | output | 16 | Start fetch address |
| fetch_addr_i | input | 16 | Program-fetch address |
| rom_sel_o | output | 1 | Fetch targets boot ROM |
| flash_sel_o | output | 1 | Fetch targets flash |
| rom_addr_o | output | 10 | Offset into boot ROM |
| aux_wr_i | input | 1 | Auxiliary register write strobe |
| aux_wdata_i | input | 8 | Auxiliary register write data |
| aux_q_o | output | 8 | Auxiliary register contents |
| erase_req_i | input | 1 | Erase request strobe |
| erase_sel_i | input | 1 | Byte named by the erase request |
| nv_erase_o | output | 2 | Erase pulse, bit 0 status, bit 1 vector |

## Verification
The bench boots with every status value, each paired with a distinct vector. A design that tested only some status bits, or that read the vector when the status is zero, would give a wrong start address or an extra read. It tries all eight strap combinations, so a forced decode that ignores one strap shows up as a stray vector jump or an unwanted status read. It flips the straps after the sample point, in both directions, to catch a design that samples continuously. It sweeps every fetch address with the overlay on and off, which exposes an off-by-one at FC00h or an overlay bit on the wrong position. It also checks that the erase pulse is linked and lasts a single cycle.

// File: rtl/bsel_pkg.sv
package bsel_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_ST_REQ,
    S_ST_DAT,
    S_VC_REQ,
    S_VC_DAT,
    S_DONE
  } boot_st_e;

  localparam logic CFG_ADDR_STATUS = 1'b0;
  localparam logic CFG_ADDR_VECTOR = 1'b1;
endpackage

// File: rtl/bsel_strap_cap.sv
module bsel_strap_cap #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sys_rst_i,
  input  logic psen_n_i,
  input  logic ea_hv_i,
  input  logic ale_i,
  output logic hold_o,
  output logic fall_q_o,
  output logic forced_q_o
);
  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] sync_q;
  logic fall_now;
  logic strap_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[CHAIN-2:0], sys_rst_i};
  end

  assign hold_o    = sync_q[SYNC_STAGES-1];
  assign fall_now  = sync_q[CHAIN-1] & ~sync_q[CHAIN-2];
  assign strap_now = ~psen_n_i & ea_hv_i & ale_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_q_o   <= 1'b0;
      forced_q_o <= 1'b0;
    end else begin
      fall_q_o <= fall_now;
      if (fall_now) forced_q_o <= strap_now;
    end
  end

  p_strap_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_now |=> $stable(forced_q_o));
  p_fall_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fall_q_o |=> !fall_q_o);
endmodule

// File: rtl/bsel_cfg_rd.sv
module bsel_cfg_rd
  import bsel_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_i,
  input  logic              fall_i,
  input  logic              forced_i,
  output logic              rd_en_o,
  output logic              rd_addr_o,
  input  logic [VEC_W-1:0]  rd_data_i,
  output logic              start_valid_o,
  output logic [ADDR_W-1:0] start_addr_o
);
  localparam int PAGE_W = ADDR_W - VEC_W;

  boot_st_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= S_IDLE;
      start_valid_o <= 1'b0;
      start_addr_o  <= '0;
    end else begin
      start_valid_o <= 1'b0;
      if (hold_i) begin
        state <= S_IDLE;
      end else begin
        unique case (state)
          S_IDLE:   if (fall_i) state <= forced_i ? S_VC_REQ : S_ST_REQ;
          S_ST_REQ: state <= S_ST_DAT;
          S_ST_DAT: begin
            if (rd_data_i == '0) begin
              start_addr_o  <= '0;
              start_valid_o <= 1'b1;
              state         <= S_DONE;
            end else begin
              state <= S_VC_REQ;
            end
          end
          S_VC_REQ: state <= S_VC_DAT;
          S_VC_DAT: begin
            start_addr_o  <= {rd_data_i, {PAGE_W{1'b0}}};
            start_valid_o <= 1'b1;
            state         <= S_DONE;
          end
          default:  state <= state;
        endcase
      end
    end
  end

  assign rd_en_o   = (state == S_ST_REQ) || (state == S_VC_REQ);
  assign rd_addr_o = (state == S_VC_REQ) ? CFG_ADDR_VECTOR : CFG_ADDR_STATUS;

  p_valid_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid_o |=> !start_valid_o);
  p_zero_status_r1: assert property (@(posedge clk) disable iff (!rst_n || hold_i)
    (state == S_ST_DAT && rd_data_i == '0) |=> (start_valid_o && start_addr_o == '0));
  p_vector_page_r2: assert property (@(posedge clk) disable iff (!rst_n || hold_i)
    (state == S_VC_DAT) |=> (start_valid_o && start_addr_o[PAGE_W-1:0] == '0
                             && start_addr_o[ADDR_W-1:PAGE_W] == $past(rd_data_i)));
  p_forced_skip_r3: assert property (@(posedge clk) disable iff (!rst_n || hold_i)
    (state == S_IDLE && fall_i && forced_i) |=> (rd_en_o && rd_addr_o == CFG_ADDR_VECTOR));
  p_no_read_in_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hold_i) |-> !rd_en_o);
endmodule

// File: rtl/bsel_fetch_dec.sv
module bsel_fetch_dec #(
  parameter int ADDR_W   = 16,
  parameter int ROM_LOG2 = 10,
  parameter int AUX_W    = 8,
  parameter int OVL_BIT  = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                aux_wr_i,
  input  logic [AUX_W-1:0]    aux_wdata_i,
  output logic [AUX_W-1:0]    aux_q_o,
  input  logic [ADDR_W-1:0]   fetch_addr_i,
  output logic                rom_sel_o,
  output logic                flash_sel_o,
  output logic [ROM_LOG2-1:0] rom_addr_o
);
  localparam int TOP_W = ADDR_W - ROM_LOG2;

  logic in_top;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        aux_q_o <= '0;
    else if (aux_wr_i) aux_q_o <= aux_wdata_i;
  end

  assign in_top      = &fetch_addr_i[ADDR_W-1:ROM_LOG2];
  assign rom_sel_o   = in_top & ~aux_q_o[OVL_BIT];
  assign flash_sel_o = ~rom_sel_o;
  assign rom_addr_o  = rom_sel_o ? fetch_addr_i[ROM_LOG2-1:0] : '0;

  p_sel_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rom_sel_o, flash_sel_o}) == 1);
  p_rom_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rom_sel_o |-> (fetch_addr_i[ADDR_W-1:ROM_LOG2] == {TOP_W{1'b1}}));
  p_overlay_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    aux_q_o[OVL_BIT] |-> (flash_sel_o && rom_addr_o == '0));
endmodule

// File: rtl/boot_start_sel.sv
module boot_start_sel #(
  parameter int ADDR_W      = 16,
  parameter int VEC_W       = 8,
  parameter int ROM_LOG2    = 10,
  parameter int AUX_W       = 8,
  parameter int OVL_BIT     = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sys_rst_i,
  input  logic                psen_n_i,
  input  logic                ea_hv_i,
  input  logic                ale_i,
  output logic                nv_rd_en_o,
  output logic                nv_rd_addr_o,
  input  logic [VEC_W-1:0]    nv_rd_data_i,
  output logic                start_valid_o,
  output logic [ADDR_W-1:0]   start_addr_o,
  input  logic [ADDR_W-1:0]   fetch_addr_i,
  output logic                rom_sel_o,
  output logic                flash_sel_o,
  output logic [ROM_LOG2-1:0] rom_addr_o,
  input  logic                aux_wr_i,
  input  logic [AUX_W-1:0]    aux_wdata_i,
  output logic [AUX_W-1:0]    aux_q_o,
  input  logic                erase_req_i,
  input  logic                erase_sel_i,
  output logic [1:0]          nv_erase_o
);
  logic hold, fall_q, forced_q;
  logic [1:0] req_mask;

  bsel_strap_cap #(.SYNC_STAGES(SYNC_STAGES)) u_strap (
    .clk(clk), .rst_n(rst_n), .sys_rst_i(sys_rst_i),
    .psen_n_i(psen_n_i), .ea_hv_i(ea_hv_i), .ale_i(ale_i),
    .hold_o(hold), .fall_q_o(fall_q), .forced_q_o(forced_q)
  );

  bsel_cfg_rd #(.ADDR_W(ADDR_W), .VEC_W(VEC_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .hold_i(hold), .fall_i(fall_q), .forced_i(forced_q),
    .rd_en_o(nv_rd_en_o), .rd_addr_o(nv_rd_addr_o), .rd_data_i(nv_rd_data_i),
    .start_valid_o(start_valid_o), .start_addr_o(start_addr_o)
  );

  bsel_fetch_dec #(.ADDR_W(ADDR_W), .ROM_LOG2(ROM_LOG2), .AUX_W(AUX_W), .OVL_BIT(OVL_BIT)) u_fetch (
    .clk(clk), .rst_n(rst_n), .aux_wr_i(aux_wr_i), .aux_wdata_i(aux_wdata_i),
    .aux_q_o(aux_q_o), .fetch_addr_i(fetch_addr_i), .rom_sel_o(rom_sel_o),
    .flash_sel_o(flash_sel_o), .rom_addr_o(rom_addr_o)
  );

  // Status and vector bytes share one erase sector: any request widens to both.
  assign req_mask = erase_req_i ? (erase_sel_i ? 2'b10 : 2'b01) : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nv_erase_o <= 2'b00;
    else        nv_erase_o <= (|req_mask) ? 2'b11 : 2'b00;
  end

  p_erase_both_r9: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req_i |=> (nv_erase_o == 2'b11));
  p_erase_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !erase_req_i |=> (nv_erase_o == 2'b00));
endmodule

// File: tb/test_boot_start_sel.sv
`timescale 1ns/100ps
module test_boot_start_sel;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sys_rst_i = 1'b1;
  logic psen_n_i = 1'b1, ea_hv_i = 1'b0, ale_i = 1'b1;
  logic nv_rd_en_o, nv_rd_addr_o;
  logic [7:0] nv_rd_data_i = 8'h00;
  logic start_valid_o;
  logic [15:0] start_addr_o;
  logic [15:0] fetch_addr_i = 16'h0000;
  logic rom_sel_o, flash_sel_o;
  logic [9:0] rom_addr_o;
  logic aux_wr_i = 1'b0;
  logic [7:0] aux_wdata_i = 8'h00;
  logic [7:0] aux_q_o;
  logic erase_req_i = 1'b0, erase_sel_i = 1'b0;
  logic [1:0] nv_erase_o;

  logic [7:0] mem_status, mem_vector;
  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  boot_start_sel i_boot_start_sel (
    .clk(clk), .rst_n(rst_n), .sys_rst_i(sys_rst_i),
    .psen_n_i(psen_n_i), .ea_hv_i(ea_hv_i), .ale_i(ale_i),
    .nv_rd_en_o(nv_rd_en_o), .nv_rd_addr_o(nv_rd_addr_o), .nv_rd_data_i(nv_rd_data_i),
    .start_valid_o(start_valid_o), .start_addr_o(start_addr_o),
    .fetch_addr_i(fetch_addr_i), .rom_sel_o(rom_sel_o), .flash_sel_o(flash_sel_o),
    .rom_addr_o(rom_addr_o), .aux_wr_i(aux_wr_i), .aux_wdata_i(aux_wdata_i),
    .aux_q_o(aux_q_o), .erase_req_i(erase_req_i), .erase_sel_i(erase_sel_i),
    .nv_erase_o(nv_erase_o)
  );

  // Nonvolatile store model: one-cycle read latency.
  always @(posedge clk)
    if (nv_rd_en_o) nv_rd_data_i <= nv_rd_addr_o ? mem_vector : mem_status;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      failures = failures + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<190000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Boot once; flip_at>=0 toggles straps to flip_val at that cycle after reset drop.
  task automatic boot(input logic [7:0] st, input logic [7:0] vec,
                      input logic pn, input logic ea, input logic al,
                      input int flip_at, input logic [2:0] flip_val,
                      input string req);
    int nvalid = 0;
    int nreads = 0;
    logic [1:0] raddr [2];
    logic [15:0] got = 16'hxxxx;
    bit forced;
    logic [15:0] exp_addr;
    int exp_reads;
    mem_status = st;
    mem_vector = vec;
    @(negedge clk);
    sys_rst_i = 1'b1;
    psen_n_i = pn; ea_hv_i = ea; ale_i = al;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (nv_rd_en_o || start_valid_o) nvalid = nvalid + 100;
    end
    sys_rst_i = 1'b0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (i == flip_at) {psen_n_i, ea_hv_i, ale_i} = flip_val;
      if (nv_rd_en_o) begin
        if (nreads < 2) raddr[nreads] = {1'b0, nv_rd_addr_o};
        nreads = nreads + 1;
      end
      if (start_valid_o) begin
        nvalid = nvalid + 1;
        got = start_addr_o;
      end
    end
    forced = (pn == 1'b0) && ea && al;
    exp_addr = (forced || st != 8'h00) ? {vec, 8'h00} : 16'h0000;
    exp_reads = forced ? 1 : ((st == 8'h00) ? 1 : 2);
    check(nvalid == 1, {req, " R6 one strobe"}, nvalid, 1);
    check(got === exp_addr, {req, " start address"}, {16'h0, got}, {16'h0, exp_addr});
    check(nreads == exp_reads, {req, " R5 read count"}, nreads, exp_reads);
    if (nreads >= 1) begin
      check(raddr[0] == (forced ? 2'd1 : 2'd0), {req, " R5 first read addr"}, raddr[0], forced ? 1 : 0);
      if (nreads == 2)
        check(raddr[1] == 2'd1, {req, " R5 second read addr"}, raddr[1], 1);
    end
  endtask

  initial begin
    mem_status = 8'h00;
    mem_vector = 8'hFC;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // Reset state (R6, R8, R9)
    check(!start_valid_o && !nv_rd_en_o, "R6 reset: no strobe or read", {start_valid_o, nv_rd_en_o}, 0);
    check(aux_q_o == 8'h00, "R8 aux reset value", aux_q_o, 0);
    check(nv_erase_o == 2'b00, "R9 erase idle at reset", nv_erase_o, 0);

    // R1/R2: every status value with a distinct vector
    for (int s = 0; s < 256; s++)
      boot(s[7:0], s[7:0] ^ 8'h5A, 1'b1, 1'b0, 1'b1, -1, 3'b000,
           (s == 0) ? "R1 zero status" : "R2 nonzero status");
    // Default vector value into the boot ROM page
    boot(8'hFF, 8'hFC, 1'b1, 1'b0, 1'b1, -1, 3'b000, "R2 default vector FCh");

    // R3: all strap combinations, both status kinds
    for (int c = 0; c < 8; c++) begin
      boot(8'h00, 8'h12, c[2], c[1], c[0], -1, 3'b000, "R3 strap combo status 0");
      boot(8'h07, 8'h34, c[2], c[1], c[0], -1, 3'b000, "R3 strap combo status 7");
    end

    // R4: strap changes after the sample point are ignored
    boot(8'h00, 8'hA5, 1'b0, 1'b1, 1'b1, 6, 3'b101, "R4 forced then released");
    boot(8'h00, 8'hA5, 1'b1, 1'b0, 1'b1, 6, 3'b011, "R4 normal then forced");

    // R7/R8: full fetch sweep, overlay on then off
    for (int ov = 0; ov < 2; ov++) begin
      int bad = 0;
      @(negedge clk);
      aux_wr_i = 1'b1;
      aux_wdata_i = (ov == 1) ? 8'h20 : 8'hDF;
      @(negedge clk);
      aux_wr_i = 1'b0;
      check(aux_q_o == aux_wdata_i, "R8 aux write", aux_q_o, aux_wdata_i);
      for (int a = 0; a < 65536; a++) begin
        bit exp_rom;
        fetch_addr_i = a[15:0];
        #0.1;
        exp_rom = (ov == 0) && (a >= 16'hFC00);
        if (rom_sel_o !== exp_rom || flash_sel_o !== !exp_rom ||
            rom_addr_o !== (exp_rom ? a[9:0] : 10'd0)) begin
          bad = bad + 1;
          if (bad < 4)
            check(1'b0, (ov == 1) ? "R8 overlay off" : "R7 overlay decode",
                  {rom_sel_o, flash_sel_o, rom_addr_o}, {exp_rom, !exp_rom, exp_rom ? a[9:0] : 10'd0});
        end
      end
      check(bad == 0, (ov == 1) ? "R8 sweep clean" : "R7 sweep clean", bad, 0);
    end
    // Boundary points explicitly, overlay back on
    @(negedge clk); aux_wr_i = 1'b1; aux_wdata_i = 8'h00;
    @(negedge clk); aux_wr_i = 1'b0;
    fetch_addr_i = 16'hFBFF; #0.1;
    check(flash_sel_o && !rom_sel_o, "R7 FBFFh is flash", rom_sel_o, 0);
    fetch_addr_i = 16'hFC00; #0.1;
    check(rom_sel_o && rom_addr_o == 10'd0, "R7 FC00h is ROM", rom_sel_o, 1);

    // R9: linked erase
    for (int e = 0; e < 2; e++) begin
      @(negedge clk);
      erase_req_i = 1'b1; erase_sel_i = e[0];
      @(negedge clk);
      erase_req_i = 1'b0;
      check(nv_erase_o == 2'b11, "R9 erase both", nv_erase_o, 3);
      @(negedge clk);
      check(nv_erase_o == 2'b00, "R9 erase single cycle", nv_erase_o, 0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule